// File: doc/BRIEF.md
# Packet-Command I2C Byte Master

This block is an I2C bus master. One command word moves at most one data byte. The host writes a command word together with a byte to send. The command word holds a 7-bit target address and a set of flags: start, send, receive, receive-last and stop. The engine then carries out the requested steps on open-drain SCL and SDA lines, in this order:

1. an optional START followed by the address phase;
2. one transmitted or received byte;
3. an optional STOP.

At the end it raises a done flag. The status word reports whether the target answered with ACK or NAK, and a buffer word presents the received byte and a bus-busy indication.

Each bit on the bus takes four phases. Each phase lasts one pulse of the `tick` input, so the host sets the SCL rate through the rate of `tick`. A target may stretch the high phase of SCL by holding the line low. When a packet ends without a STOP, the master keeps SCL low and so keeps the bus. The next command can then continue the transfer with more bytes, or it can issue a repeated START.

Top module: `i2c_pkt_master`

## Requirements
- R1: A command is accepted only when all of the following hold:
  - `cmd_word[16]` (enable) is 1.
  - Every bit outside {30:24, 16, 5, 4, 3, 1, 0} is 0.
  - The engine is idle.

  The fields are: address [30:24], stop bit 5, receive-last bit 4, receive bit 3, send bit 1, start bit 0. A rejected command causes no bus activity and no status change.
- R2: With start set, the engine issues a START and then the address byte {addr, rw}, most significant bit first. rw is 1 when receive is set and 0 otherwise.
- R3: A command with start and no send or receive flag performs only the address phase (a probe).
- R4: In the send case, `tx_byte` is shifted out most significant bit first. For the address byte and for a sent data byte, a target ACK sets status bit 0 and a target NAK sets status bit 1.
- R5: A received byte appears at `buf_word[15:8]`. The master answers it with ACK, or with NAK when receive-last is set.
- R6: At the end of every packet, status bit 16 (done) is set. Writing a 1 to a status bit through `sts_clr_wr`/`sts_clr_mask` clears that bit. A set event and a clear in the same cycle leave the bit set.
- R7: `buf_word[16]` (busy) is 1 from the START condition until the STOP condition.
  - With stop set, the packet ends with a STOP.
  - Without stop, SCL stays driven low after the packet, and the next command with start produces a repeated START with no STOP in between.
  - A data command on a free bus inserts a START first.
- R8: If the address phase is NAKed, the data phase is skipped. A STOP is still issued if one was requested, and done is still set.
- R9: A command written while a packet is in progress is ignored.
- R10: After reset, both lines are released and the status and buffer words read 0. SDA changes while SCL is released only to form a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One pulse per bus phase (four phases per bit) |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| tx_byte | input | 8 | Byte to send, captured with the command |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 32 | Write-one-to-clear mask for the status word |
| sts_word | output | 32 | Status: bit 16 done, bit 1 NAK, bit 0 ACK |
| buf_word | output | 32 | Buffer: bits 15:8 received byte, bit 16 busy |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Four properties are checked on every cycle:
- SDA moves under a released SCL only during START or STOP.
- A byte is clocked only while the bus is marked busy.
- An address NAK never leads into a data byte.
- The latched command cannot change once a packet is running, and every completion or ACK/NAK event lands in the sticky status.

Other behaviour can only be shown by the bench's scenarios against a behavioural target on the wired-AND lines:
- the exact address byte, including the rw bit, for every one of the 128 addresses;
- the bytes sent and received;
- the master's ACK/NAK choice on reads;
- repeated START without an intervening STOP;
- rejection of disabled or overlapping commands.

// File: rtl/i2c_pkt_pkg.sv
package i2c_pkt_pkg;
  localparam int REG_W       = 32;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 7;
  localparam int PH_W        = 2;
  localparam int BITCNT_W    = $clog2(BYTE_W + 1);
  localparam int F_START     = 0;
  localparam int F_TX        = 1;
  localparam int F_RX        = 3;
  localparam int F_LAST      = 4;
  localparam int F_STOP      = 5;
  localparam int F_EN        = 16;
  localparam int F_ADDR_LSB  = 24;
  localparam int S_DONE_BIT  = 16;
  localparam int S_NAK_BIT   = 1;
  localparam int S_ACK_BIT   = 0;
  localparam int B_BUSY_BIT  = 16;
  localparam int B_RX_LSB    = 8;

  localparam logic [REG_W-1:0] CMD_USED =
    (((REG_W'(1) << ADDR_W) - 1) << F_ADDR_LSB) | (REG_W'(1) << F_EN) |
    (REG_W'(1) << F_STOP) | (REG_W'(1) << F_LAST) | (REG_W'(1) << F_RX) |
    (REG_W'(1) << F_TX) | (REG_W'(1) << F_START);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic start;
    logic tx;
    logic rx;
    logic last;
    logic stop;
  } pkt_cmd_t;

  typedef enum logic [2:0] {SQ_IDLE, SQ_START, SQ_BYTE, SQ_STOP, SQ_DONE} seq_st_t;

  function automatic pkt_cmd_t cmd_unpack(input logic [REG_W-1:0] w);
    pkt_cmd_t c;
    c.addr  = w[F_ADDR_LSB +: ADDR_W];
    c.start = w[F_START];
    c.tx    = w[F_TX];
    c.rx    = w[F_RX];
    c.last  = w[F_LAST];
    c.stop  = w[F_STOP];
    return c;
  endfunction

  function automatic logic [BYTE_W-1:0] addr_byte(input logic [ADDR_W-1:0] a, input logic rd);
    return {a, rd};
  endfunction
endpackage

// File: rtl/i2c_pkt_cmd_dec.sv
module i2c_pkt_cmd_dec
  import i2c_pkt_pkg::*;
(
  input  logic             cmd_wr,
  input  logic [REG_W-1:0] cmd_word,
  input  logic             seq_idle,
  output logic             cmd_go,
  output pkt_cmd_t         cmd
);
  logic enable_ok;
  logic reserved_clear;

  assign enable_ok      = cmd_word[F_EN];
  assign reserved_clear = ((cmd_word & ~CMD_USED) == '0);
  assign cmd_go         = cmd_wr && enable_ok && reserved_clear && seq_idle;
  assign cmd            = cmd_unpack(cmd_word);
endmodule

// File: rtl/i2c_pkt_seq.sv
module i2c_pkt_seq
  import i2c_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_go,
  input  pkt_cmd_t          cmd_in,
  input  logic [BYTE_W-1:0] tx_in,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              idle,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ev_done,
  output logic              ev_ack,
  output logic              ev_nak
);
  localparam logic [PH_W-1:0]     PH_LAST = '1;
  localparam logic [BITCNT_W-1:0] ACK_SLOT = BITCNT_W'(BYTE_W);

  seq_st_t               st_q;
  logic [PH_W-1:0]       ph_q;
  logic [BITCNT_W-1:0]   bit_q;
  logic [BYTE_W-1:0]     sh_q, txb_q, rx_q;
  logic                  smp_q, data_q, busy_q;
  pkt_cmd_t              flg_q;

  logic     step, stalled, byte_end, rx_data, addr_nak_evt;
  seq_st_t  after_st;

  assign stalled  = (ph_q == PH_W'(1)) && !scl_in;
  assign step     = tick && !stalled;
  assign byte_end = step && (ph_q == PH_LAST) && (bit_q == ACK_SLOT);
  assign rx_data  = data_q && flg_q.rx;
  assign after_st = flg_q.stop ? SQ_STOP : SQ_DONE;
  assign addr_nak_evt = (st_q == SQ_BYTE) && !data_q && byte_end && smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; ph_q <= '0; bit_q <= '0; sh_q <= '0; txb_q <= '0;
      rx_q <= '0; smp_q <= 1'b0; data_q <= 1'b0; busy_q <= 1'b0; flg_q <= '0;
      ev_done <= 1'b0; ev_ack <= 1'b0; ev_nak <= 1'b0;
    end else begin
      ev_done <= 1'b0; ev_ack <= 1'b0; ev_nak <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (cmd_go) begin
          flg_q <= cmd_in; txb_q <= tx_in; ph_q <= '0; bit_q <= '0;
          if (cmd_in.start || (!busy_q && (cmd_in.tx || cmd_in.rx))) begin
            st_q <= SQ_START; data_q <= 1'b0;
          end else if (cmd_in.tx || cmd_in.rx) begin
            st_q <= SQ_BYTE; data_q <= 1'b1;
            sh_q <= cmd_in.rx ? '0 : tx_in;
          end else begin
            st_q <= cmd_in.stop ? SQ_STOP : SQ_DONE;
          end
        end
        SQ_START: if (step) begin
          ph_q <= ph_q + PH_W'(1);
          if (ph_q == PH_W'(1)) busy_q <= 1'b1;
          if (ph_q == PH_LAST) begin
            st_q <= SQ_BYTE; bit_q <= '0;
            sh_q <= addr_byte(flg_q.addr, flg_q.rx);
          end
        end
        SQ_BYTE: if (step) begin
          ph_q <= ph_q + PH_W'(1);
          if (ph_q == PH_W'(2)) smp_q <= sda_in;
          if (ph_q == PH_LAST) begin
            if (bit_q != ACK_SLOT) begin
              sh_q  <= {sh_q[BYTE_W-2:0], smp_q};
              bit_q <= bit_q + BITCNT_W'(1);
            end else begin
              bit_q <= '0;
              if (!data_q) begin
                if (smp_q) begin
                  ev_nak <= 1'b1; st_q <= after_st;
                end else begin
                  ev_ack <= 1'b1;
                  if (flg_q.tx || flg_q.rx) begin
                    data_q <= 1'b1;
                    sh_q   <= flg_q.rx ? '0 : txb_q;
                  end else begin
                    st_q <= after_st;
                  end
                end
              end else begin
                if (flg_q.rx) rx_q <= sh_q;
                else if (smp_q) ev_nak <= 1'b1;
                else ev_ack <= 1'b1;
                st_q <= after_st;
              end
            end
          end
        end
        SQ_STOP: if (step) begin
          ph_q <= ph_q + PH_W'(1);
          if (ph_q == PH_W'(1)) busy_q <= 1'b0;
          if (ph_q == PH_LAST) st_q <= SQ_DONE;
        end
        SQ_DONE: begin
          ev_done <= 1'b1;
          st_q    <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    unique case (st_q)
      SQ_START: begin
        scl_oe = (ph_q == '0) ? busy_q : (ph_q == PH_LAST);
        sda_oe = (ph_q >= PH_W'(2));
      end
      SQ_BYTE: begin
        scl_oe = (ph_q == '0) || (ph_q == PH_LAST);
        if (bit_q == ACK_SLOT) sda_oe = rx_data && !flg_q.last;
        else                   sda_oe = !rx_data && !sh_q[BYTE_W-1];
      end
      SQ_STOP: begin
        scl_oe = (ph_q == '0);
        sda_oe = (ph_q <= PH_W'(1));
      end
      default: scl_oe = busy_q;
    endcase
  end

  assign busy    = busy_q;
  assign idle    = (st_q == SQ_IDLE);
  assign rx_byte = rx_q;

  a_r10_sda_moves_only_for_conditions: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (st_q == SQ_START || st_q == SQ_STOP));
  a_r7_byte_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_BYTE) |-> busy_q);
  a_r8_nak_skips_data: assert property (@(posedge clk) disable iff (!rst_n)
    addr_nak_evt |=> (st_q != SQ_BYTE));
  a_r9_cmd_frozen_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_IDLE) |=> $stable(flg_q));
endmodule

// File: rtl/i2c_pkt_sts.sv
module i2c_pkt_sts #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] sts_q
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_eff) | set_vec;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    a_r6_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> sts_q[i]);
  end
endmodule

// File: rtl/i2c_pkt_master.sv
module i2c_pkt_master
  import i2c_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_wr,
  input  logic [REG_W-1:0]  cmd_word,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sts_clr_wr,
  input  logic [REG_W-1:0]  sts_clr_mask,
  output logic [REG_W-1:0]  sts_word,
  output logic [REG_W-1:0]  buf_word,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic              cmd_go, seq_idle, busy, ev_done, ev_ack, ev_nak;
  pkt_cmd_t          cmd;
  logic [BYTE_W-1:0] rx_byte;
  logic [REG_W-1:0]  set_vec;

  i2c_pkt_cmd_dec u_dec (
    .cmd_wr(cmd_wr), .cmd_word(cmd_word), .seq_idle(seq_idle),
    .cmd_go(cmd_go), .cmd(cmd)
  );

  i2c_pkt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_go(cmd_go), .cmd_in(cmd),
    .tx_in(tx_byte), .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .busy(busy), .idle(seq_idle), .rx_byte(rx_byte),
    .ev_done(ev_done), .ev_ack(ev_ack), .ev_nak(ev_nak)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[S_DONE_BIT] = ev_done;
    set_vec[S_NAK_BIT]  = ev_nak;
    set_vec[S_ACK_BIT]  = ev_ack;
    buf_word                        = '0;
    buf_word[B_BUSY_BIT]            = busy;
    buf_word[B_RX_LSB +: BYTE_W]    = rx_byte;
  end

  i2c_pkt_sts #(.W(REG_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_wr(sts_clr_wr),
    .clr_mask(sts_clr_mask), .sts_q(sts_word)
  );
endmodule

// File: tb/tb_i2c_pkt_master.sv
`timescale 1ns/1ps
module tb_i2c_pkt_master;
  localparam logic [6:0] SLV = 7'h2A;
  localparam logic [6:0] OTHER = 7'h11;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cmd_wr = 1'b0, sts_clr_wr = 1'b0;
  logic [31:0] cmd_word = '0, sts_clr_mask = '0, sts_word, buf_word;
  logic [7:0]  tx_byte = '0;
  logic scl_oe, sda_oe, scl_line, sda_line, slv_drv;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_drv);

  i2c_pkt_master dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .tx_byte(tx_byte), .sts_clr_wr(sts_clr_wr), .sts_clr_mask(sts_clr_mask),
    .sts_word(sts_word), .buf_word(buf_word), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // tick every fourth clock
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      tick = (cnt == 3);
      cnt = (cnt + 1) % 4;
    end
  end

  // behavioural target on the wired-AND lines
  logic scl_q, sda_q, s_act, s_skip, s_match, s_rw, s_mnak, s_mack;
  logic [7:0] s_sh, s_addr_seen, s_wr_last, rd_base;
  int s_bitn, s_byten, s_starts, s_stops, s_wr_cnt;

  function automatic logic [7:0] rd_val(input int k);
    return rd_base + 8'(k - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; s_act <= 1'b0; s_skip <= 1'b0; s_match <= 1'b0;
      s_rw <= 1'b0; s_mnak <= 1'b0; s_mack <= 1'b0; s_sh <= '0; s_addr_seen <= '0;
      s_wr_last <= '0; s_bitn <= 0; s_byten <= 0; s_starts <= 0; s_stops <= 0;
      s_wr_cnt <= 0; slv_drv <= 1'b0;
    end else begin
      scl_q <= scl_line; sda_q <= sda_line;
      if (scl_q && scl_line && sda_q && !sda_line) begin
        s_starts <= s_starts + 1; s_act <= 1'b1; s_skip <= 1'b1; s_bitn <= 0;
        s_byten <= 0; s_mnak <= 1'b0; slv_drv <= 1'b0;
      end else if (scl_q && scl_line && !sda_q && sda_line) begin
        s_stops <= s_stops + 1; s_act <= 1'b0; slv_drv <= 1'b0;
      end else if (s_act && !scl_q && scl_line) begin
        if (s_bitn < 8) s_sh <= {s_sh[6:0], sda_line};
        else if (s_rw && s_byten > 0) begin s_mack <= !sda_line; s_mnak <= sda_line; end
      end else if (s_act && scl_q && !scl_line) begin
        if (s_skip) s_skip <= 1'b0;
        else if (s_bitn == 7) begin
          s_bitn <= 8;
          if (s_byten == 0) begin
            s_addr_seen <= s_sh; s_match <= (s_sh[7:1] == SLV); s_rw <= s_sh[0];
            slv_drv <= (s_sh[7:1] == SLV);
          end else if (!s_rw && s_match) begin
            s_wr_last <= s_sh; s_wr_cnt <= s_wr_cnt + 1; slv_drv <= 1'b1;
          end else slv_drv <= 1'b0;
        end else if (s_bitn == 8) begin
          s_bitn <= 0; s_byten <= s_byten + 1;
          slv_drv <= s_match && s_rw && !s_mnak && !rd_val(s_byten + 1)[7];
        end else begin
          slv_drv <= s_match && s_rw && (s_byten > 0) && !s_mnak && !rd_val(s_byten)[6 - s_bitn];
          s_bitn <= s_bitn + 1;
        end
      end
    end
  end

  function automatic logic [31:0] mk(input logic [6:0] a, input bit st, input bit tx,
      input bit rx, input bit last, input bit stop, input bit en);
    return (32'(a) << 24) | (32'(en) << 16) | (32'(stop) << 5) | (32'(last) << 4) |
           (32'(rx) << 3) | (32'(tx) << 1) | 32'(st);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [7:0] d);
    @(negedge clk); cmd_word = w; tx_byte = d; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!sts_word[16] && n < 4000) begin @(negedge clk); n++; end
    chk(req, 32'(sts_word[16]), 32'd1);
  endtask

  task automatic clr(input logic [31:0] m);
    @(negedge clk); sts_clr_mask = m; sts_clr_wr = 1'b1;
    @(negedge clk); sts_clr_wr = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int st0, sp0, wc0;
    logic [7:0] d;
    rd_base = 8'h00;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 sts", sts_word, 32'h0);
    chk("R10 buf", buf_word, 32'h0);
    chk("R10 lines", {30'd0, scl_oe, sda_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2/R3 exhaustive probe sweep with stop
    for (int a = 0; a < 128; a++) begin
      issue(mk(7'(a), 1, 0, 0, 0, 1, 1), 8'h00);
      wait_done("R3 done");
      chk("R3 ack/nak", sts_word, (7'(a) == SLV) ? 32'h0001_0001 : 32'h0001_0002);
      chk("R2 address byte", 32'(s_addr_seen), 32'(a * 2));
      chk("R7 free after stop", 32'(buf_word[16]), 32'd0);
      clr(32'hFFFF_FFFF);
    end

    // R4 send sweep
    for (int k = 0; k < 16; k++) begin
      d = 8'(k * 17) ^ 8'h5A;
      wc0 = s_wr_cnt;
      issue(mk(SLV, 1, 1, 0, 0, 1, 1), d);
      wait_done("R4 done");
      chk("R4 ack", sts_word, 32'h0001_0001);
      chk("R4 byte", 32'(s_wr_last), 32'(d));
      chk("R4 one byte", 32'(s_wr_cnt), 32'(wc0 + 1));
      clr(32'hFFFF_FFFF);
    end

    // R5/R2 single reads with last
    for (int k = 0; k < 8; k++) begin
      rd_base = 8'(k * 37 + 3);
      issue(mk(SLV, 1, 0, 1, 1, 1, 1), 8'h00);
      wait_done("R5 done");
      chk("R5 rx byte", 32'(buf_word[15:8]), 32'(rd_base));
      chk("R2 rw bit", 32'(s_addr_seen), 32'(SLV) * 2 + 1);
      chk("R5 last gets NAK", 32'(s_mack), 32'd0);
      clr(32'hFFFF_FFFF);
    end

    // R5/R7 two-byte read across two commands
    rd_base = 8'hC0;
    issue(mk(SLV, 1, 0, 1, 0, 0, 1), 8'h00);
    wait_done("R5 first");
    chk("R5 first byte", 32'(buf_word[15:8]), 32'hC0);
    chk("R5 master ACK", 32'(s_mack), 32'd1);
    chk("R7 held busy", 32'(buf_word[16]), 32'd1);
    clr(32'hFFFF_FFFF);
    issue(mk(SLV, 0, 0, 1, 1, 1, 1), 8'h00);
    wait_done("R5 second");
    chk("R5 second byte", 32'(buf_word[15:8]), 32'hC1);
    chk("R5 master NAK", 32'(s_mack), 32'd0);
    chk("R7 released", 32'(buf_word[16]), 32'd0);
    clr(32'hFFFF_FFFF);

    // R7 held write then repeated START read
    sp0 = s_stops; st0 = s_starts; rd_base = 8'h6D;
    issue(mk(SLV, 1, 1, 0, 0, 0, 1), 8'h33);
    wait_done("R7 held write");
    repeat (20) @(negedge clk);
    chk("R7 busy held", 32'(buf_word[16]), 32'd1);
    chk("R7 SCL held low", 32'(scl_line), 32'd0);
    clr(32'hFFFF_FFFF);
    issue(mk(SLV, 1, 0, 1, 1, 1, 1), 8'h00);
    wait_done("R7 restart read");
    chk("R7 two STARTs", 32'(s_starts), 32'(st0 + 2));
    chk("R7 single STOP", 32'(s_stops), 32'(sp0 + 1));
    chk("R7 restart data", 32'(buf_word[15:8]), 32'h6D);
    chk("R10 lines idle", {30'd0, scl_line, sda_line}, 32'h3);
    clr(32'hFFFF_FFFF);

    // R8 address NAK with send and stop
    wc0 = s_wr_cnt;
    issue(mk(OTHER, 1, 1, 0, 0, 1, 1), 8'h77);
    wait_done("R8 done");
    chk("R8 nak only", sts_word, 32'h0001_0002);
    chk("R8 no data byte", 32'(s_wr_cnt), 32'(wc0));
    chk("R8 stop issued", 32'(buf_word[16]), 32'd0);
    clr(32'hFFFF_FFFF);
    issue(mk(OTHER, 1, 1, 0, 0, 0, 1), 8'h77);
    wait_done("R8 no-stop done");
    chk("R8 bus kept", 32'(buf_word[16]), 32'd1);
    clr(32'hFFFF_FFFF);
    issue(mk(7'h00, 0, 0, 0, 0, 1, 1), 8'h00);
    wait_done("R7 stop-only");
    chk("R7 stop-only status", sts_word, 32'h0001_0000);
    chk("R7 stop-only frees bus", 32'(buf_word[16]), 32'd0);
    clr(32'hFFFF_FFFF);

    // R6 write-one-to-clear
    issue(mk(SLV, 1, 0, 0, 0, 1, 1), 8'h00);
    wait_done("R6 done");
    clr(32'h0001_0000);
    chk("R6 clear done only", sts_word, 32'h0000_0001);
    clr(32'h0000_0001);
    chk("R6 clear ack", sts_word, 32'h0);

    // R9 overlapping command ignored
    st0 = s_starts;
    issue(mk(SLV, 1, 0, 0, 0, 1, 1), 8'h00);
    repeat (40) @(negedge clk);
    issue(mk(OTHER, 1, 0, 0, 0, 1, 1), 8'h00);
    wait_done("R9 done");
    chk("R9 first result", sts_word, 32'h0001_0001);
    clr(32'hFFFF_FFFF);
    repeat (600) @(negedge clk);
    chk("R9 no second packet", sts_word, 32'h0);
    chk("R9 one START", 32'(s_starts), 32'(st0 + 1));
    chk("R9 address kept", 32'(s_addr_seen), 32'(SLV) * 2);

    // R1 disabled and reserved-bit commands rejected
    st0 = s_starts;
    issue(mk(SLV, 1, 0, 0, 0, 1, 0), 8'h00);
    repeat (600) @(negedge clk);
    chk("R1 enable clear ignored", sts_word, 32'h0);
    issue(mk(SLV, 1, 0, 0, 0, 1, 1) | 32'h0000_0004, 8'h00);
    repeat (600) @(negedge clk);
    chk("R1 reserved bit ignored", sts_word, 32'h0);
    chk("R1 no bus activity", 32'(s_starts), 32'(st0));

    finish_run();
  end
endmodule